// File: doc/BRIEF.md
# Segment Scan and Drive Level Encoder

This block drives the column side of a dot-matrix liquid crystal panel. A line counter, kept in step with the row driver by a frame pulse, chooses which panel line is on display. The block adds a start-line offset to that count, reads the row out of a page-organised display RAM one column byte at a time, and gathers one bit from each byte into a row buffer. On each rising edge of the line clock the buffer is copied into an output latch. Each latched pixel is then turned into a 2-bit code that selects one of four bias levels, chosen from the pixel value and the alternation phase.

All logic runs on one system clock. The line clock and the frame signal are sampled into that domain, and their edges are found there. The alternation phase, display-enable and direction inputs are levels that are assumed to be synchronous to the system clock. The display RAM is read through a port that returns data one clock after it is given an address. A full row fetch takes NCOL+2 clocks, so the rising edge of the line clock must come at least NCOL+8 clocks after the falling edge before it. The bias voltages themselves are produced outside this block.

Top module: `seg_scan_drive`

## Requirements
- R1: Reset is synchronous and active-low. It clears the line counter and the output latch. One clock after reset is released, every segment code is the non-select level for the current phase.
- R2: Level codes are V0=2'b00, V2=2'b01, V3=2'b10 and V5=2'b11. With phase low, a pixel of 1 gives V0 and a pixel of 0 gives V2. With phase high, a pixel of 1 gives V5 and a pixel of 0 gives V3.
- R3: While display-enable is low, every segment shows the non-select level for the current phase (V2 for phase low, V3 for phase high), whatever the RAM holds.
- R4: The output latch loads the row buffer only on a rising edge of the line clock. At all other times it holds its value.
- R5: The 6-bit line counter advances by one on each falling edge of the line clock and wraps from 63 back to 0.
- R6: A rising edge of the frame signal loads the line counter with 0. This takes priority over a falling edge of the line clock detected in the same cycle.
- R7: The fetched line is (counter + start_line) mod 64. start_line is sampled when a fetch begins: once after reset, and once after each falling edge of the line clock and each edge of the frame signal. A change made after that point does not affect the row already fetched.
- R8: The row for line L is read from RAM address page*NCOL + column, where page = L div 8. Bit (L mod 8) of each byte is taken. Columns are read in order from 0 to NCOL-1, one per clock, starting the clock after the fetch begins.
- R9: Segment s occupies bits [2s+1:2s] of seg_code. When col_fwd is high it shows column s; when col_fwd is low it shows column NCOL-1-s.
- R10: seg_code is registered. A change on ac_phase, disp_on or col_fwd appears one clock later without any line clock activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line clock: rising edge latches the row, falling edge advances the line |
| frame_in | input | 1 | Frame sync: rising edge zeroes the line counter |
| ac_phase | input | 1 | Alternation phase for the drive waveform |
| disp_on | input | 1 | Display enable; low forces non-select levels |
| start_line | input | 6 | Line offset added to the counter |
| col_fwd | input | 1 | Column-to-segment direction |
| ram_rd_en | output | 1 | Read strobe, high while a row fetch runs |
| ram_rd_addr | output | 9 | Read address {page, column} |
| ram_rd_data | input | 8 | Read data, valid one clock after the address |
| seg_code | output | 128 | Two-bit level code per segment |

## Verification
The bench builds the block with its default parameters: 64 columns and 64 lines, so the address is 9 bits wide and there are 8 pages. At this size the counter wraps after a run of 64 line pulses, and start-line offsets near 63 carry into the next frame's low lines. Both direction settings map the two end segments to the opposite physical columns. A bench-side RAM filled with a varied pattern means that selecting the wrong bit, page or column gives a visibly wrong code.

// File: rtl/seg_scan_pkg.sv
// Package: shared level codes and geometry constants for the segment scan block.
// Assumes each RAM byte holds eight vertically stacked pixel rows.
package seg_scan_pkg;

    localparam int BYTE_W    = 8;
    localparam int ROW_SEL_W = 3;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } lvl_t;

    // Map phase, pixel and enable to the level code of one segment.
    function automatic logic [1:0] lvl_pick(input logic phase, input logic px, input logic on);
        lvl_t l;
        if (!on || !px) begin
            l = phase ? LVL_V3 : LVL_V2;
        end else begin
            l = phase ? LVL_V5 : LVL_V0;
        end
        return l;
    endfunction

endpackage

// File: rtl/seg_edge_sync.sv
// Module: brings an asynchronous level into the clock domain and flags its edges.
// Assumes the input is slow compared with clk; each edge gives a one-cycle pulse.
module seg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] shr_q;

    // Shift the input through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else begin
            shr_q <= {shr_q[STAGES-1:0], din};
        end
    end

    assign rise = shr_q[STAGES-1] & ~shr_q[STAGES];
    assign fall = ~shr_q[STAGES-1] & shr_q[STAGES];

endmodule

// File: rtl/seg_line_counter.sv
// Module: scan line counter, zeroed by frame sync and stepped by the line clock.
// Assumes both pulses last one cycle; frame takes priority.
module seg_line_counter #(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              step,
    output logic [LINE_W-1:0] cnt
);

    // Hold, zero or advance the counter; it wraps by its width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (preset) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + LINE_W'(1);
        end
    end

endmodule

// File: rtl/seg_row_gather.sv
// Module: reads one byte per column from the display RAM and collects one bit
// from each into a row buffer. Assumes the RAM returns data one clock after
// the address; a new start restarts the walk from column 0.
module seg_row_gather
    import seg_scan_pkg::*;
#(
    parameter int NCOL   = 64,
    parameter int LINE_W = 6,
    localparam int COL_W  = $clog2(NCOL),
    localparam int PAGE_W = LINE_W - ROW_SEL_W,
    localparam int ADDR_W = PAGE_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [NCOL-1:0]   row
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOL - 1);

    logic                 busy_q;
    logic [COL_W-1:0]     col_q;
    logic [LINE_W-1:0]    line_q;
    logic                 vld_d;
    logic [COL_W-1:0]     col_d;
    logic [ROW_SEL_W-1:0] bit_d;

    // Address walker: capture the line at start, then step through the columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            col_q  <= '0;
            line_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            col_q  <= '0;
            line_q <= line;
        end else if (busy_q) begin
            col_q <= col_q + COL_W'(1);
            if (col_q == LAST_COL) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Delay stage that lines the column tag up with the returning RAM data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d <= 1'b0;
            col_d <= '0;
            bit_d <= '0;
        end else begin
            vld_d <= busy_q & ~start;
            col_d <= col_q;
            bit_d <= line_q[ROW_SEL_W-1:0];
        end
    end

    // Row buffer: store the selected bit of each returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (vld_d) begin
            row[col_d] <= rd_data[bit_d];
        end
    end

    assign rd_en   = busy_q;
    assign rd_addr = {line_q[LINE_W-1:ROW_SEL_W], col_q};

endmodule

// File: rtl/seg_level_encoder.sv
// Module: maps latched pixels to segments in either direction and registers
// one level code per segment. Assumes its control levels are synchronous to clk.
module seg_level_encoder
    import seg_scan_pkg::*;
#(
    parameter int NCOL = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCOL-1:0]   row,
    input  logic              ac_phase,
    input  logic              disp_on,
    input  logic              col_fwd,
    output logic [2*NCOL-1:0] seg_code
);

    localparam logic [1:0] RST_LVL = LVL_V2;

    logic [NCOL-1:0] picked;

    // Column selection for each segment under the direction input.
    for (genvar s = 0; s < NCOL; s++) begin : g_map
        assign picked[s] = col_fwd ? row[s] : row[NCOL-1-s];
    end

    // Register the level code of every segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_code <= {NCOL{RST_LVL}};
        end else begin
            for (int s = 0; s < NCOL; s++) begin
                seg_code[2*s +: 2] <= lvl_pick(ac_phase, picked[s], disp_on);
            end
        end
    end

endmodule

// File: rtl/seg_scan_drive.sv
// Top: segment scan and drive level encoder. Syncs the line and frame strobes,
// keeps the scan line, fetches each row from RAM, latches it on the line clock
// and encodes the drive levels. Assumes rising line edges come at least
// NCOL+8 clocks after the falling edge before them.
module seg_scan_drive
    import seg_scan_pkg::*;
#(
    parameter int NCOL  = 64,
    parameter int NLINE = 64,
    localparam int LINE_W = $clog2(NLINE),
    localparam int COL_W  = $clog2(NCOL),
    localparam int ADDR_W = LINE_W - ROW_SEL_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              frame_in,
    input  logic              ac_phase,
    input  logic              disp_on,
    input  logic [LINE_W-1:0] start_line,
    input  logic              col_fwd,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_rd_addr,
    input  logic [BYTE_W-1:0] ram_rd_data,
    output logic [2*NCOL-1:0] seg_code
);

    logic              cl_rise, cl_fall;
    logic              frm_rise, frm_fall;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] disp_line;
    logic              fetch_start;
    logic [NCOL-1:0]   row_buf;
    logic [NCOL-1:0]   row_latch;

    seg_edge_sync u_cl_sync (
        .clk (clk), .rst_n (rst_n), .din (line_clk),
        .rise (cl_rise), .fall (cl_fall)
    );

    seg_edge_sync u_frm_sync (
        .clk (clk), .rst_n (rst_n), .din (frame_in),
        .rise (frm_rise), .fall (frm_fall)
    );

    seg_line_counter #(.LINE_W(LINE_W)) u_ctr (
        .clk (clk), .rst_n (rst_n), .preset (frm_rise),
        .step (cl_fall), .cnt (line_cnt)
    );

    assign disp_line = line_cnt + start_line;

    // Fetch request: once out of reset, then one cycle after each counter event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_start <= 1'b1;
        end else begin
            fetch_start <= cl_fall | frm_rise | frm_fall;
        end
    end

    seg_row_gather #(.NCOL(NCOL), .LINE_W(LINE_W)) u_gather (
        .clk (clk), .rst_n (rst_n), .start (fetch_start), .line (disp_line),
        .rd_en (ram_rd_en), .rd_addr (ram_rd_addr), .rd_data (ram_rd_data),
        .row (row_buf)
    );

    // Output latch: take the fetched row on each rising line clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_latch <= '0;
        end else if (cl_rise) begin
            row_latch <= row_buf;
        end
    end

    seg_level_encoder #(.NCOL(NCOL)) u_enc (
        .clk (clk), .rst_n (rst_n), .row (row_latch),
        .ac_phase (ac_phase), .disp_on (disp_on), .col_fwd (col_fwd),
        .seg_code (seg_code)
    );

endmodule

// File: rtl/seg_scan_drive_chk.sv
// Checker: temporal properties of the segment scan block, bound to its top.
module seg_scan_drive_chk #(
    parameter int NCOL  = 64,
    parameter int NLINE = 64,
    localparam int LINE_W = $clog2(NLINE),
    localparam int COL_W  = $clog2(NCOL),
    localparam int ADDR_W = LINE_W - 3 + COL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cl_rise,
    input logic              cl_fall,
    input logic              frm_rise,
    input logic              fetch_start,
    input logic [LINE_W-1:0] line_cnt,
    input logic [NCOL-1:0]   row_buf,
    input logic [NCOL-1:0]   row_latch,
    input logic              disp_on,
    input logic              ac_phase,
    input logic              ram_rd_en,
    input logic [ADDR_W-1:0] ram_rd_addr,
    input logic [2*NCOL-1:0] seg_code
);

    logic [NCOL-1:0]  sel_vec;
    logic [NCOL-1:0]  msb_vec;
    logic [COL_W-1:0] col;

    for (genvar s = 0; s < NCOL; s++) begin : g_split
        assign sel_vec[s] = ~(seg_code[2*s+1] ^ seg_code[2*s]);
        assign msb_vec[s] = seg_code[2*s+1];
    end
    assign col = ram_rd_addr[COL_W-1:0];

    a_r6_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rise |=> line_cnt == '0);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_fall && !frm_rise) |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));

    a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cl_fall && !frm_rise) |=> $stable(line_cnt));

    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_rise |=> $stable(row_latch));

    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        cl_rise |=> row_latch == $past(row_buf));

    a_r3_off_nonselect: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> $countones(sel_vec) == 0);

    a_r2_phase_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> msb_vec == {NCOL{$past(ac_phase)}});

    a_r8_walk_begin: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> (ram_rd_en && col == '0));

    a_r8_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en && !fetch_start && col != COL_W'(NCOL - 1))
        |=> (ram_rd_en && col == COL_W'($past(col) + 1'b1)));

endmodule

bind seg_scan_drive seg_scan_drive_chk #(.NCOL(NCOL), .NLINE(NLINE)) u_chk (
    .clk (clk), .rst_n (rst_n), .cl_rise (cl_rise), .cl_fall (cl_fall),
    .frm_rise (frm_rise), .fetch_start (fetch_start), .line_cnt (line_cnt),
    .row_buf (row_buf), .row_latch (row_latch), .disp_on (disp_on),
    .ac_phase (ac_phase), .ram_rd_en (ram_rd_en), .ram_rd_addr (ram_rd_addr),
    .seg_code (seg_code)
);

// File: tb/seg_scan_drive_bench.sv
module seg_scan_drive_bench;

    localparam int NC = 64;
    localparam int NV = 6;
    // Vector: [14:9] start line, [8] direction, [7] phase, [6] enable, [5:0] line pulses
    localparam logic [14:0] VEC [NV] = '{
        {6'd0,  1'b1, 1'b0, 1'b1, 6'd3},
        {6'd5,  1'b0, 1'b1, 1'b1, 6'd3},
        {6'd62, 1'b1, 1'b1, 1'b1, 6'd4},
        {6'd17, 1'b0, 1'b0, 1'b0, 6'd2},
        {6'd33, 1'b1, 1'b0, 1'b1, 6'd2},
        {6'd8,  1'b0, 1'b1, 1'b0, 6'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_clk = 1'b0;
    logic         frame_in = 1'b0;
    logic         ac_phase = 1'b0;
    logic         disp_on = 1'b1;
    logic [5:0]   start_line = '0;
    logic         col_fwd = 1'b1;
    logic         ram_rd_en;
    logic [8:0]   ram_rd_addr;
    logic [7:0]   ram_rd_data = '0;
    logic [127:0] seg_code;

    logic [7:0] mem [512];
    int checks = 0;
    int failures = 0;
    int ctr = 0;
    int fl = 0;
    int lat_line = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_scan_drive u_seg_scan_drive (
        .clk (clk), .rst_n (rst_n), .line_clk (line_clk), .frame_in (frame_in),
        .ac_phase (ac_phase), .disp_on (disp_on), .start_line (start_line),
        .col_fwd (col_fwd), .ram_rd_en (ram_rd_en), .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data), .seg_code (seg_code)
    );

    // Registered RAM model: data one clock after the address.
    always @(posedge clk) ram_rd_data <= mem[ram_rd_addr];

    // Expected codes from R2, R3, R8 and R9.
    function automatic logic [127:0] exp_row(int line, logic ph, logic on, logic fwd);
        logic [127:0] r;
        for (int s = 0; s < NC; s++) begin
            int c = fwd ? s : NC - 1 - s;
            logic px = mem[(line / 8) * NC + c][line % 8];
            logic [1:0] l;
            if (!on || !px) l = ph ? 2'b10 : 2'b01;
            else            l = ph ? 2'b11 : 2'b00;
            r[2*s +: 2] = l;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] exp);
        checks++;
        if (seg_code !== exp) begin
            failures++;
            $display("FAIL %s line=%0d got=%h exp=%h", req, lat_line, seg_code, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_pulse();
        frame_in = 1'b1;
        wait_clk(6);
        frame_in = 1'b0;
        wait_clk(100);
        ctr = 0;
        fl = int'(start_line);
    endtask

    task automatic line_period(string req, bit do_chk);
        line_clk = 1'b1;
        wait_clk(8);
        lat_line = fl;
        if (do_chk) chk(req, exp_row(lat_line, ac_phase, disp_on, col_fwd));
        line_clk = 1'b0;
        wait_clk(100);
        ctr = (ctr + 1) % 64;
        fl = (ctr + int'(start_line)) % 64;
    endtask

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3) ^ (a * 5 >> 2));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset leaves the latch clear, all non-select for phase low
        chk("R1", {NC{2'b01}});
        wait_clk(100);

        // Table walk: R2, R3, R5, R7, R8, R9
        for (int v = 0; v < NV; v++) begin
            start_line = VEC[v][14:9];
            col_fwd    = VEC[v][8];
            ac_phase   = VEC[v][7];
            disp_on    = VEC[v][6];
            frame_pulse();
            for (int k = 0; k < int'(VEC[v][5:0]); k++) line_period("R7", 1'b1);
        end

        // R10 and R2: phase flip without line clock activity
        disp_on = 1'b1;
        ac_phase = ~ac_phase;
        wait_clk(3);
        chk("R10", exp_row(lat_line, ac_phase, disp_on, col_fwd));
        // R9: direction flip reorders the held row
        col_fwd = ~col_fwd;
        wait_clk(3);
        chk("R9", exp_row(lat_line, ac_phase, disp_on, col_fwd));
        // R3: disable forces non-select
        disp_on = 1'b0;
        wait_clk(3);
        chk("R3", {NC{ac_phase ? 2'b10 : 2'b01}});
        disp_on = 1'b1;

        // R6: frame in mid-scan restarts at the start line
        start_line = 6'd20;
        frame_pulse();
        line_period("R6", 1'b0);
        line_period("R6", 1'b0);
        frame_pulse();
        line_period("R6", 1'b1);

        // R7: start line changed after the fetch does not alter the fetched row
        start_line = 6'd44;
        line_clk = 1'b1;
        wait_clk(8);
        lat_line = fl;
        chk("R7", exp_row(lat_line, ac_phase, disp_on, col_fwd));
        line_clk = 1'b0;
        wait_clk(100);
        ctr = (ctr + 1) % 64;
        fl = (ctr + 44) % 64;

        // R4: a new fetch without a rising edge leaves the output alone
        frame_pulse();
        chk("R4", exp_row(lat_line, ac_phase, disp_on, col_fwd));

        // R5: 64 line pulses wrap the counter back to the start line
        start_line = 6'd0;
        col_fwd = 1'b1;
        ac_phase = 1'b0;
        frame_pulse();
        for (int k = 0; k < 64; k++) line_period("R5", 1'b0);
        line_period("R5", 1'b1);
        if (lat_line != 0) begin
            failures++;
            $display("FAIL R5 wrap line=%0d exp=0", lat_line);
        end
        checks++;

        // R8: full walk across all pages at phase high
        ac_phase = 1'b1;
        for (int k = 0; k < 63; k++) line_period("R8", 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule